// File: doc/BRIEF.md
# NAND Flash Read Pointer Device Model

A synthesizable device-side model of a small NAND flash front end, meant to sit behind a host controller inside a testbench or an emulation build. All traffic arrives on one 8-bit bus. Strobes with the command-latch input high are commands. Strobes with the address-latch input high are address bytes. Strobes with neither high are data. The model keeps a read pointer that selects the lower data half, the upper data half or the spare bytes. A read starts with one column byte and two row bytes. The model then pulls ready low for a fixed number of clocks and afterwards returns one byte per read-enable pulse from a computed backing pattern.

Pages are 528 bytes. Columns 0 to 511 are data and 512 to 527 are the spare bytes. A row is block number times 16 plus page number. A spare-lock input hides the spare bytes: a spare pointer request is refused, and sequential reads skip those columns. Program and erase sequences are decoded only so that their busy windows and the chip-enable rules can be exercised. Nothing is stored.

All pins are sampled on the model clock. A write strobe counts on its sampled rising edge. A read strobe counts on its sampled falling edge. Each counts only while chip enable (active low) is asserted.

Top module: `nand_rp_model`

## Requirements
- R1: After reset, readyOut is 1 and ioOe is 0, and the pointer selects the lower half.
- R2: Command 00h followed by three address bytes (column, row bits 7:0, row bits 12:8 taken from bits 4:0 with bits 7:5 ignored) reads from column = column byte. The byte at row r and column c is c[7:0] ^ r[7:0] ^ {c[9:8], r[12:8], 1'b0}.
- R3: Command 01h starts at column 256 + column byte. After that read has begun, the pointer falls back to the lower half. A read opened by address bytes alone (no command) then starts in the lower half.
- R4: Command 50h with spareLock low starts at column 512 + column byte bits 3:0. The spare pointer persists, so reads opened by address bytes alone stay in the spare bytes.
- R5: With spareLock high, command 50h is ignored and leaves the pointer unchanged. A sequential read ends each page at column 511 and moves on to the next row at column 0.
- R6: Each sampled falling edge of reN in the data phase puts the byte at the column counter on ioOut, visible one clock later, and advances the counter by one. ioOe is 1 only while ceN and reN are both low in the data phase.
- R7: readyOut is low for exactly READ_DELAY clocks after the third address byte of a read.
- R8: With spareLock low, a read crosses from column 255 to 256 and from 511 to 512 without a break. After column 527 it continues at column 0 of the next row, or at column 512 when the read was started with the spare pointer.
- R9: Address bytes beyond the third are ignored and change neither the row nor the column.
- R10: ceN high during a read busy window or data phase returns the model to standby: readyOut is high and reN pulses no longer enable the bus. Write strobes with ceN high are not latched.
- R11: 80h, three address bytes, data bytes, then 10h hold readyOut low for PROG_DELAY clocks. 60h, two address bytes, then D0h hold it low for ERASE_DELAY clocks. ceN high during these windows does not end them.
- R12: Command FFh is accepted even while busy. It ends any busy window at once and sets the pointer back to the lower half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; all pins sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip enable, active low |
| cleIn | input | 1 | Marks a write strobe as a command |
| aleIn | input | 1 | Marks a write strobe as an address byte |
| weN | input | 1 | Write strobe, active low; latched on its rising edge |
| reN | input | 1 | Read strobe, active low; steps on its falling edge |
| spareLock | input | 1 | High hides the spare bytes |
| ioIn | input | 8 | Command, address or data byte from the host |
| ioOut | output | 8 | Read data byte |
| ioOe | output | 1 | Bus drive enable for ioOut |
| readyOut | output | 1 | High when ready, low while busy |

## Verification
Two events can land in the same cycle and are tested that way. A standby request (ceN rising) can meet a running read busy countdown, and a reset command can arrive while any busy window is open. The bench raises ceN on the sample right after the third address byte. It then checks that ready is back on the next sample and that a later read pulse leaves the bus undriven. It also issues FFh inside a read busy window and checks that ready returns at once and that the next bare-address read starts in the lower half. The same overlap for program busy is checked the other way round: there ceN high must not shorten the window.

// File: rtl/nand_rp_pkg.sv
package nand_rp_pkg;

  // which region a read begins in
  typedef enum logic [1:0] {
    PTR_LOW   = 2'd0,
    PTR_HIGH  = 2'd1,
    PTR_SPARE = 2'd2
  } ptrSel_t;

  // strobes from control to datapath, one clock wide
  typedef struct packed {
    logic    setPtr;
    ptrSel_t newPtr;
    logic    resetPtr;
    logic    loadCol;
    logic    loadRowLo;
    logic    loadRowHi;
    logic    startRead;
    logic    stepCol;
  } dpStrobe_t;

  localparam logic [7:0] OP_READ_LO     = 8'h00;
  localparam logic [7:0] OP_READ_HI     = 8'h01;
  localparam logic [7:0] OP_READ_SPARE  = 8'h50;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_GO     = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_RESET       = 8'hFF;

endpackage

// File: rtl/nand_rp_ctrl.sv
module nand_rp_ctrl
  import nand_rp_pkg::*;
#(
  parameter int READ_DELAY  = 8,
  parameter int PROG_DELAY  = 20,
  parameter int ERASE_DELAY = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weN,
  input  logic       reN,
  input  logic       spareLock,
  input  logic [7:0] ioIn,
  output dpStrobe_t  stbOut,
  output logic       readyOut,
  output logic       ioOe
);

  localparam int MAX_A     = (READ_DELAY > PROG_DELAY) ? READ_DELAY : PROG_DELAY;
  localparam int MAX_DELAY = (MAX_A > ERASE_DELAY) ? MAX_A : ERASE_DELAY;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RADDR, ST_RBUSY, ST_RDATA, ST_PADDR, ST_EADDR, ST_WBUSY
  } state_t;

  state_t     state, nextState;
  logic [CNT_W-1:0] busyCnt, nextCnt;
  logic [1:0] addrIdx, nextIdx, slotIdx;
  logic       weD, reD;
  logic       weRise, reFall, cmdStrobe, addrStrobe, resetCmd;

  // strobe edge detection against the previous sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weD <= 1'b1;
      reD <= 1'b1;
    end else begin
      weD <= weN;
      reD <= reN;
    end
  end

  assign weRise     = weN & ~weD & ~ceN;
  assign reFall     = ~reN & reD & ~ceN;
  assign cmdStrobe  = weRise & cleIn & ~aleIn;
  assign addrStrobe = weRise & aleIn & ~cleIn;
  assign resetCmd   = cmdStrobe && (ioIn == OP_RESET);
  // a bare address outside an address phase opens a new read
  assign slotIdx    = (state == ST_RADDR) ? addrIdx : 2'd0;

  always_comb begin
    stbOut    = '0;
    nextState = state;
    nextCnt   = busyCnt;
    nextIdx   = addrIdx;
    if (resetCmd) begin
      stbOut.resetPtr = 1'b1;
      nextState       = ST_IDLE;
      nextCnt         = '0;
      nextIdx         = 2'd0;
    end else begin
      case (state)
        ST_IDLE, ST_RADDR, ST_RDATA: begin
          if (state == ST_RDATA && ceN) begin
            nextState = ST_IDLE;
          end else if (cmdStrobe) begin
            nextIdx = 2'd0;
            case (ioIn)
              OP_READ_LO: begin
                stbOut.setPtr = 1'b1;
                stbOut.newPtr = PTR_LOW;
                nextState     = ST_RADDR;
              end
              OP_READ_HI: begin
                stbOut.setPtr = 1'b1;
                stbOut.newPtr = PTR_HIGH;
                nextState     = ST_RADDR;
              end
              OP_READ_SPARE: begin
                if (!spareLock) begin
                  stbOut.setPtr = 1'b1;
                  stbOut.newPtr = PTR_SPARE;
                  nextState     = ST_RADDR;
                end
              end
              OP_PROG_SETUP:  nextState = ST_PADDR;
              OP_ERASE_SETUP: nextState = ST_EADDR;
              default: ;
            endcase
          end else if (addrStrobe) begin
            case (slotIdx)
              2'd0: begin
                stbOut.loadCol = 1'b1;
                nextIdx        = 2'd1;
                nextState      = ST_RADDR;
              end
              2'd1: begin
                stbOut.loadRowLo = 1'b1;
                nextIdx          = 2'd2;
              end
              default: begin
                stbOut.loadRowHi = 1'b1;
                stbOut.startRead = 1'b1;
                nextIdx          = 2'd0;
                nextCnt          = CNT_W'(READ_DELAY - 1);
                nextState        = ST_RBUSY;
              end
            endcase
          end else if (state == ST_RDATA && reFall) begin
            stbOut.stepCol = 1'b1;
          end
        end
        ST_RBUSY: begin
          if (ceN) begin
            nextState = ST_IDLE;
          end else if (busyCnt == '0) begin
            nextState = ST_RDATA;
          end else begin
            nextCnt = busyCnt - 1'b1;
          end
        end
        ST_PADDR: begin
          if (cmdStrobe && ioIn == OP_PROG_GO) begin
            nextCnt   = CNT_W'(PROG_DELAY - 1);
            nextState = ST_WBUSY;
          end
        end
        ST_EADDR: begin
          if (cmdStrobe && ioIn == OP_ERASE_GO) begin
            nextCnt   = CNT_W'(ERASE_DELAY - 1);
            nextState = ST_WBUSY;
          end
        end
        ST_WBUSY: begin
          if (busyCnt == '0) nextState = ST_IDLE;
          else               nextCnt   = busyCnt - 1'b1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyCnt <= '0;
      addrIdx <= 2'd0;
    end else begin
      state   <= nextState;
      busyCnt <= nextCnt;
      addrIdx <= nextIdx;
    end
  end

  assign readyOut = (state != ST_RBUSY) && (state != ST_WBUSY);
  assign ioOe     = (state == ST_RDATA) && !ceN && !reN;

  // R7: read busy window is not cut short while enabled
  a_r7_read_busy_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RBUSY && busyCnt != '0 && !ceN && !resetCmd) |=> !readyOut);

  // R7: the window closes when the count is used up
  a_r7_read_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RBUSY && busyCnt == '0 && !ceN && !resetCmd) |=> readyOut);

  // R10: chip enable high during read busy means standby
  a_r10_standby: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RBUSY && ceN) |=> (readyOut && !ioOe));

  // R11: chip enable high does not end program or erase busy
  a_r11_ce_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WBUSY && ceN && busyCnt != '0) |=> !readyOut);

  // R12: reset command ends busy at once
  a_r12_reset_ready: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> readyOut);

endmodule

// File: rtl/nand_rp_dpath.sv
module nand_rp_dpath
  import nand_rp_pkg::*;
#(
  parameter int BLOCKS          = 512,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int DATA_BYTES      = 512,
  parameter int SPARE_BYTES     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stbIn,
  input  logic       spareLock,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut
);

  localparam int ROWS        = BLOCKS * PAGES_PER_BLOCK;
  localparam int ROW_W       = $clog2(ROWS);
  localparam int ROW_HI_W    = ROW_W - 8;
  localparam int PAGE_BYTES  = DATA_BYTES + SPARE_BYTES;
  localparam int COL_W       = $clog2(PAGE_BYTES);
  localparam int HALF_BYTES  = DATA_BYTES / 2;
  localparam int SPARE_SEL_W = $clog2(SPARE_BYTES);

  ptrSel_t          curPtr;
  logic [7:0]       colLatch;
  logic [ROW_W-1:0] rowAddr;
  logic [COL_W-1:0] colCnt, colBase, colLimit;
  logic             inSpare, atLast;
  logic [7:0]       outByte;

  // backing content: a pure function of row and column
  function automatic logic [7:0] patternByte(input logic [ROW_W-1:0] r,
                                             input logic [COL_W-1:0] c);
    logic [7:0] colMix, rowMix;
    colMix = 8'(c >> 8) << 6;
    rowMix = 8'(r >> 8) << 1;
    return c[7:0] ^ r[7:0] ^ colMix ^ rowMix;
  endfunction

  always_comb begin
    case (curPtr)
      PTR_HIGH:  colBase = COL_W'(HALF_BYTES) + COL_W'(colLatch);
      PTR_SPARE: colBase = COL_W'(DATA_BYTES) + COL_W'(colLatch[SPARE_SEL_W-1:0]);
      default:   colBase = COL_W'(colLatch);
    endcase
  end

  assign colLimit = spareLock ? COL_W'(DATA_BYTES - 1) : COL_W'(PAGE_BYTES - 1);
  assign atLast   = colCnt >= colLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr   <= PTR_LOW;
      colLatch <= '0;
      rowAddr  <= '0;
      colCnt   <= '0;
      inSpare  <= 1'b0;
      outByte  <= '0;
    end else begin
      if (stbIn.resetPtr)                             curPtr <= PTR_LOW;
      else if (stbIn.setPtr)                          curPtr <= stbIn.newPtr;
      else if (stbIn.startRead && curPtr == PTR_HIGH) curPtr <= PTR_LOW;

      if (stbIn.loadCol)   colLatch <= ioIn;
      if (stbIn.loadRowLo) rowAddr[7:0] <= ioIn;
      if (stbIn.loadRowHi) rowAddr[ROW_W-1:8] <= ioIn[ROW_HI_W-1:0];

      if (stbIn.startRead) begin
        colCnt  <= colBase;
        inSpare <= (curPtr == PTR_SPARE);
      end else if (stbIn.stepCol) begin
        outByte <= patternByte(rowAddr, colCnt);
        if (atLast) begin
          colCnt  <= inSpare ? COL_W'(DATA_BYTES) : '0;
          rowAddr <= rowAddr + 1'b1;
        end else begin
          colCnt <= colCnt + 1'b1;
        end
      end
    end
  end

  assign ioOut = outByte;

  // R6: one read pulse advances the column by one inside a page
  a_r6_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (stbIn.stepCol && !stbIn.startRead && !atLast) |=> colCnt == $past(colCnt) + 1'b1);

  // R8: leaving the last column moves to the next row
  a_r8_row_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stbIn.stepCol && !stbIn.startRead && !stbIn.loadRowHi && atLast)
      |=> rowAddr == $past(rowAddr) + 1'b1);

  // R5: a spare request never reaches the pointer while locked
  a_r5_spare_gate: assert property (@(posedge clk) disable iff (!rstN)
    (stbIn.setPtr && spareLock) |-> stbIn.newPtr != PTR_SPARE);

  // R5: a locked read begins inside the data columns
  a_r5_lock_start: assert property (@(posedge clk) disable iff (!rstN)
    (stbIn.startRead && spareLock && curPtr != PTR_SPARE) |=> colCnt < COL_W'(DATA_BYTES));

  // R3: the upper-half selection serves one read only
  a_r3_fallback: assert property (@(posedge clk) disable iff (!rstN)
    (stbIn.startRead && curPtr == PTR_HIGH && !stbIn.setPtr && !stbIn.resetPtr)
      |=> curPtr == PTR_LOW);

endmodule

// File: rtl/nand_rp_model.sv
module nand_rp_model
  import nand_rp_pkg::*;
#(
  parameter int READ_DELAY      = 8,
  parameter int PROG_DELAY      = 20,
  parameter int ERASE_DELAY     = 30,
  parameter int BLOCKS          = 512,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int DATA_BYTES      = 512,
  parameter int SPARE_BYTES     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weN,
  input  logic       reN,
  input  logic       spareLock,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       readyOut
);

  dpStrobe_t stb;

  nand_rp_ctrl #(
    .READ_DELAY (READ_DELAY),
    .PROG_DELAY (PROG_DELAY),
    .ERASE_DELAY(ERASE_DELAY)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .cleIn    (cleIn),
    .aleIn    (aleIn),
    .weN      (weN),
    .reN      (reN),
    .spareLock(spareLock),
    .ioIn     (ioIn),
    .stbOut   (stb),
    .readyOut (readyOut),
    .ioOe     (ioOe)
  );

  nand_rp_dpath #(
    .BLOCKS         (BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .DATA_BYTES     (DATA_BYTES),
    .SPARE_BYTES    (SPARE_BYTES)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stbIn    (stb),
    .spareLock(spareLock),
    .ioIn     (ioIn),
    .ioOut    (ioOut)
  );

endmodule

// File: tb/test_nand_rp_model.sv
module test_nand_rp_model;

  localparam int READ_DELAY  = 8;
  localparam int PROG_DELAY  = 20;
  localparam int ERASE_DELAY = 30;

  logic       clk = 1'b0;
  logic       rstN, ceN, cleIn, aleIn, weN, reN, spareLock;
  logic [7:0] ioIn, ioOut;
  logic       ioOe, readyOut;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  nand_rp_model #(
    .READ_DELAY (READ_DELAY),
    .PROG_DELAY (PROG_DELAY),
    .ERASE_DELAY(ERASE_DELAY)
  ) i_nand_rp_model (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn),
    .weN(weN), .reN(reN), .spareLock(spareLock), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .readyOut(readyOut)
  );

  // vectors: {command, column byte, row low, row high}
  localparam logic [31:0] VECS [6] = '{
    32'h00_00_00_00, 32'h00_A5_34_E3, 32'h01_00_12_01,
    32'h01_7F_FF_1F, 32'h50_03_40_00, 32'h50_FE_02_1F
  };

  function automatic logic [7:0] expByte(input int row, input int col);
    logic [12:0] r;
    logic [9:0]  c;
    r = 13'(row);
    c = 10'(col);
    return c[7:0] ^ r[7:0] ^ {c[9:8], r[12:8], 1'b0};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cleIn = c; aleIn = a; ioIn = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    cleIn = 1'b0; aleIn = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] d);
    busWrite(1'b1, 1'b0, d);
  endtask

  task automatic sendAddr(input logic [7:0] d);
    busWrite(1'b0, 1'b1, d);
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!readyOut && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic readByte(output logic [7:0] b, output logic oeLow, output logic oeHigh);
    @(negedge clk);
    reN = 1'b0;
    @(negedge clk);
    b = ioOut;
    oeLow = ioOe;
    reN = 1'b1;
    @(negedge clk);
    oeHigh = ioOe;
  endtask

  // reads n bytes, expected column walk follows R6/R8/R5
  task automatic readExpect(input string req, input int row, input int col,
                            input int n, input bit spareRead);
    logic [7:0] b;
    logic oeL, oeH;
    int r, c, limit;
    r = row;
    c = col;
    for (int k = 0; k < n; k++) begin
      readByte(b, oeL, oeH);
      check(req, b, expByte(r, c));
      check("R6 oe", {oeL, oeH}, 2'b10);
      limit = spareLock ? 511 : 527;
      if (c >= limit) begin
        c = spareRead ? 512 : 0;
        r = (r + 1) % 8192;
      end else begin
        c++;
      end
    end
  endtask

  task automatic openRead(input logic [7:0] op, input logic [7:0] col,
                          input logic [7:0] rlo, input logic [7:0] rhi, output int n);
    sendCmd(op);
    sendAddr(col);
    sendAddr(rlo);
    sendAddr(rhi);
    waitReady(n);
  endtask

  task automatic bareRead(input logic [7:0] col, input logic [7:0] rlo,
                          input logic [7:0] rhi, output int n);
    sendAddr(col);
    sendAddr(rlo);
    sendAddr(rhi);
    waitReady(n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n, row, col;
    logic [7:0] b;
    logic oeL, oeH;
    rstN = 1'b0; ceN = 1'b0; cleIn = 1'b0; aleIn = 1'b0;
    weN = 1'b1; reN = 1'b1; spareLock = 1'b0; ioIn = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and default lower-half pointer
    check("R1 ready", readyOut, 1);
    check("R1 oe", ioOe, 0);
    bareRead(8'h10, 8'h05, 8'h00, n);
    readExpect("R1 pointer", 5, 16, 2, 1'b0);

    // table walk over R2, R3, R4 with R7 busy length
    for (int v = 0; v < 6; v++) begin
      logic [7:0] op, cb, rl, rh;
      {op, cb, rl, rh} = VECS[v];
      openRead(op, cb, rl, rh, n);
      check("R7 busy", n, READ_DELAY);
      row = {rh[4:0], rl};
      if (op == 8'h00)      col = cb;
      else if (op == 8'h01) col = 256 + cb;
      else                  col = 512 + cb[3:0];
      if (op == 8'h00)      readExpect("R2 vector", row, col, 3, 1'b0);
      else if (op == 8'h01) readExpect("R3 vector", row, col, 3, 1'b0);
      else                  readExpect("R4 vector", row, col, 3, 1'b1);
    end

    // R3 upper half serves one read, then lower half
    openRead(8'h01, 8'h20, 8'h07, 8'h00, n);
    readExpect("R3 upper", 7, 288, 1, 1'b0);
    bareRead(8'h20, 8'h07, 8'h00, n);
    readExpect("R3 fallback", 7, 32, 1, 1'b0);

    // R4 spare pointer persists
    openRead(8'h50, 8'h05, 8'h09, 8'h00, n);
    readExpect("R4 spare", 9, 517, 1, 1'b1);
    bareRead(8'h06, 8'h09, 8'h00, n);
    readExpect("R4 persist", 9, 518, 1, 1'b1);

    // R8 boundaries with spare bytes visible
    openRead(8'h01, 8'hFF, 8'h20, 8'h00, n);
    readExpect("R8 511 to 512", 32, 511, 3, 1'b0);
    openRead(8'h50, 8'h0F, 8'h21, 8'h00, n);
    readExpect("R8 spare wrap", 33, 527, 2, 1'b1);
    openRead(8'h00, 8'hFF, 8'h22, 8'h00, n);
    readExpect("R8 half cross", 34, 255, 2, 1'b0);

    // R5 spare lock
    openRead(8'h00, 8'h00, 8'h00, 8'h00, n);
    spareLock = 1'b1;
    sendCmd(8'h50);
    bareRead(8'h04, 8'h30, 8'h00, n);
    readExpect("R5 50h ignored", 48, 4, 1, 1'b0);
    openRead(8'h01, 8'hFE, 8'h31, 8'h00, n);
    readExpect("R5 skip spare", 49, 510, 3, 1'b0);
    spareLock = 1'b0;

    // R9 extra address byte during busy
    sendCmd(8'h00);
    sendAddr(8'h40);
    sendAddr(8'h11);
    sendAddr(8'h00);
    sendAddr(8'h99);
    waitReady(n);
    readExpect("R9 extra addr", 17, 64, 2, 1'b0);

    // R10 chip enable high during read busy
    sendCmd(8'h00);
    sendAddr(8'h01);
    sendAddr(8'h02);
    sendAddr(8'h00);
    ceN = 1'b1;
    @(negedge clk);
    check("R10 busy standby ready", readyOut, 1);
    ceN = 1'b0;
    readByte(b, oeL, oeH);
    check("R10 busy standby oe", oeL, 0);

    // R10 chip enable high during data phase
    openRead(8'h00, 8'h01, 8'h02, 8'h00, n);
    readExpect("R10 pre", 2, 1, 1, 1'b0);
    ceN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b0;
    readByte(b, oeL, oeH);
    check("R10 data standby oe", oeL, 0);

    // R10 write strobe ignored with chip enable high
    ceN = 1'b1;
    sendCmd(8'h01);
    ceN = 1'b0;
    bareRead(8'h09, 8'h03, 8'h00, n);
    readExpect("R10 we ignored", 3, 9, 1, 1'b0);

    // R11 program busy, chip enable high ignored
    sendCmd(8'h80);
    sendAddr(8'h00);
    sendAddr(8'h00);
    sendAddr(8'h00);
    busWrite(1'b0, 1'b0, 8'hAA);
    busWrite(1'b0, 1'b0, 8'h55);
    sendCmd(8'h10);
    ceN = 1'b1;
    waitReady(n);
    ceN = 1'b0;
    check("R11 program busy", n, PROG_DELAY);
    sendCmd(8'h60);
    sendAddr(8'h10);
    sendAddr(8'h00);
    sendCmd(8'hD0);
    waitReady(n);
    check("R11 erase busy", n, ERASE_DELAY);

    // R12 reset command during read busy
    sendCmd(8'h50);
    sendAddr(8'h02);
    sendAddr(8'h04);
    sendAddr(8'h00);
    check("R12 busy before", readyOut, 0);
    sendCmd(8'hFF);
    check("R12 ready after", readyOut, 1);
    bareRead(8'h02, 8'h04, 8'h00, n);
    readExpect("R12 pointer", 4, 2, 1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule